// File: doc/BRIEF.md
# Parallel ATA programmed-I/O strobe timer

This block sits between a host I/O port and a parallel ATA cable and runs one programmed-I/O read or write at a time. It checks each host address against the command and control windows of two channels. For an address that hits an enabled channel it raises the read or the write strobe and counts a programmed number of clocks before it first looks at the device ready line. If ready sampling is on for the selected drive and the line is low, it holds the strobe. Once the cycle is over it drops the strobe and waits a programmed recovery gap before it takes the next request.

Each channel has a 16-bit timing word, and one shared slave word holds a separate 4-bit timing code for drive 1 of each channel. The current drive of each channel follows bit 4 of the last write to command offset 6. A bit in the timing word decides whether drive 1 uses the channel's main codes or its slave code. The DMA fast-timing and prefetch bits are stored but leave PIO timing unchanged.

Top module: `ide_pio_strobe`

## Requirements
- R1: After reset, both strobes, `done` and `busy` are low. Both timing words are 0000h, so no address produces a strobe.
- R2: A request is taken only when `busy` is low and the address hits an enabled channel. Channel 0 decodes 1F0h–1F7h (command) and 3F6h (control). Channel 1 decodes 170h–177h and 376h. Bit 15 of a channel's timing word enables that channel. Any other address, or a disabled channel, gives no strobe and no `done`. `dev_cs` is 01 for a command address and 10 for a control address, and `dev_addr` carries address bits 2:0.
- R3: With ready high, the strobe is high for N clocks. N comes from sample code bits 13:12: 00=5, 01=4, 10=3, and the reserved 11=5.
- R4: With requests held back to back, the strobe is low for exactly R clocks between cycles. R comes from recovery bits 9:8: 00=4, 01=3, 10=2, 11=1.
- R5: When ready sampling is on for the selected drive, a low ready at the sample point holds the strobe high. Ready is then resampled every clock, and the strobe stays high for N plus the number of low samples.
- R6: When ready sampling is off for the selected drive, a low ready has no effect and the strobe width stays N.
- R7: When timing-word bit 14 is set and drive 1 is selected, N and R come from the slave word. Channel 0 uses bits 3:2 (sample) and 1:0 (recovery), and channel 1 uses bits 7:6 and 5:4. When bit 14 is clear, drive 1 uses bits 13:12 and 9:8.
- R8: Bit 4 of a write to command offset 6 selects the drive for later cycles on that channel. Ready sampling is enabled by timing-word bit 1 for drive 0 and by bit 5 for drive 1. Drive 0 never uses the slave word.
- R9: A write raises only `strb_wr` and drives `dev_wdata` with the request data. A read raises only `strb_rd`. `done` pulses for one clock in the first clock that the strobe is low, and after a read `rdata` holds the `dev_rdata` value seen at the last sample.
- R10: Timing-word bits 0, 2, 4 and 6 (DMA fast timing, prefetch) do not change PIO strobe width or recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0: channel 0 timing word, 1: channel 1 timing word, 2: slave word |
| cfg_data | input | 16 | Configuration write data |
| req | input | 1 | Host I/O request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host I/O address |
| req_wdata | input | DATA_W | Host write data |
| busy | output | 1 | Cycle or recovery in progress; requests are not taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Data captured on a read |
| strb_rd | output | 1 | Read strobe, active high |
| strb_wr | output | 1 | Write strobe, active high |
| dev_rdy | input | 1 | Device ready line |
| dev_rdata | input | DATA_W | Data from the device |
| dev_wdata | output | DATA_W | Data to the device |
| dev_addr | output | 3 | Register offset within the block |
| dev_cs | output | 2 | Bit 0 command block, bit 1 control block |
| dev_chan | output | 1 | Channel of the current cycle |

## Verification
The hardest case to reach is slave timing for drive 1. It needs a channel with bit 14 set, a slave code written, and a prior device/head write with bit 4 high. Even then the change only shows up as a different strobe width and recovery gap. Each table row therefore configures the words, issues a real write to offset 6 to set the drive, then holds two reads back to back so both width and gap are measured. A bench-driven ready line goes low for a chosen number of samples after the sample point to show stall and ignore behaviour for each drive.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
   localparam int N_CHAN = 2;
   localparam logic [9:0] CMD_BASE [N_CHAN] = '{10'h1F0, 10'h170};
   localparam logic [9:0] CTL_ADDR [N_CHAN] = '{10'h3F6, 10'h376};

   // bit positions inside a channel timing word
   localparam int B_DEC_EN  = 15;
   localparam int B_D1_SEP  = 14;
   localparam int B_RDY_D0  = 1;
   localparam int B_RDY_D1  = 5;

   typedef struct packed {
      logic [1:0] smp;
      logic [1:0] rec;
   } tcode_t;

   function automatic logic [2:0] smp_clks(input logic [1:0] c, input logic rsv_slow);
      case (c)
         2'b00:   smp_clks = 3'd5;
         2'b01:   smp_clks = 3'd4;
         2'b10:   smp_clks = 3'd3;
         default: smp_clks = rsv_slow ? 3'd5 : 3'd3;
      endcase
   endfunction

   function automatic logic [2:0] rec_clks(input logic [1:0] c);
      rec_clks = 3'd4 - {1'b0, c};
   endfunction
endpackage

// File: rtl/ide_addr_dec.sv
module ide_addr_dec #(
   parameter int ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        chan_en,
   output logic              hit,
   output logic              chan,
   output logic              is_ctl
);
   import ide_pio_pkg::*;

   logic [N_CHAN-1:0] cmd_m, ctl_m, hit_v;
   logic              hi_zero;

   if (ADDR_W > 10) begin : g_wide
      assign hi_zero = (addr[ADDR_W-1:10] == '0);
   end else begin : g_narrow
      assign hi_zero = 1'b1;
   end

   for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
      assign cmd_m[c] = hi_zero && (addr[9:3] == CMD_BASE[c][9:3]);
      assign ctl_m[c] = hi_zero && (addr[9:0] == CTL_ADDR[c]);
      assign hit_v[c] = chan_en[c] && (cmd_m[c] || ctl_m[c]);
   end

   assign hit    = |hit_v;
   assign chan   = hit_v[1];
   assign is_ctl = |(ctl_m & chan_en);
endmodule

// File: rtl/ide_tim_regs.sv
module ide_tim_regs (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [1:0]           cfg_sel,
   input  logic [15:0]          cfg_data,
   output logic [15:0]          tim [2],
   output ide_pio_pkg::tcode_t  slv [2]
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tim[0] <= '0;
         tim[1] <= '0;
         slv[0] <= '0;
         slv[1] <= '0;
      end else if (cfg_wr) begin
         case (cfg_sel)
            2'd0: tim[0] <= cfg_data;
            2'd1: tim[1] <= cfg_data;
            2'd2: begin
               slv[0] <= cfg_data[3:0];
               slv[1] <= cfg_data[7:4];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ide_strobe_fsm.sv
module ide_strobe_fsm #(
   parameter int CNT_W  = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_wr,
   input  logic [CNT_W-1:0]  n_clk,
   input  logic [CNT_W-1:0]  r_clk,
   input  logic              rdy_en,
   input  logic              rdy,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] rdata_in,
   output logic              strb_rd,
   output logic              strb_wr,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] wdata_o
);
   logic             act, wr_q, ie_q;
   logic [CNT_W-1:0] scnt, rcnt, rlat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= 1'b0; wr_q <= 1'b0; ie_q <= 1'b0; done <= 1'b0;
         scnt <= '0; rcnt <= '0; rlat <= '0;
         rdata <= '0; wdata_o <= '0;
      end else begin
         done <= 1'b0;
         if (rcnt != '0) rcnt <= rcnt - CNT_W'(1);
         if (!act && start) begin
            act     <= 1'b1;
            wr_q    <= is_wr;
            ie_q    <= rdy_en;
            scnt    <= n_clk - CNT_W'(1);
            rlat    <= r_clk;
            wdata_o <= wdata;
         end else if (act) begin
            if (scnt != '0) begin
               scnt <= scnt - CNT_W'(1);
            end else if (!ie_q || rdy) begin
               act   <= 1'b0;
               done  <= 1'b1;
               rcnt  <= rlat - CNT_W'(1);
               rdata <= rdata_in;
            end
         end
      end
   end

   assign strb_rd = act && !wr_q;
   assign strb_wr = act && wr_q;
   assign busy    = act || (rcnt != '0);

   p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(strb_rd && strb_wr));
   p_done_first_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!strb_rd && !strb_wr && $past(strb_rd || strb_wr)));
   p_stall_on_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb_rd || strb_wr) |-> $past(!ie_q || rdy));
   p_full_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb_rd || strb_wr) |-> ($past(scnt) == '0));
endmodule

// File: rtl/ide_pio_strobe.sv
module ide_pio_strobe #(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 3,
   parameter bit RSV_SLOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [15:0]       cfg_data,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              strb_rd,
   output logic              strb_wr,
   input  logic              dev_rdy,
   input  logic [DATA_W-1:0] dev_rdata,
   output logic [DATA_W-1:0] dev_wdata,
   output logic [2:0]        dev_addr,
   output logic [1:0]        dev_cs,
   output logic              dev_chan
);
   import ide_pio_pkg::*;

   if (ADDR_W < 10) $error("ADDR_W must cover 10 address bits");
   if (CNT_W < 3)   $error("CNT_W must hold a count of 5");
   if (DATA_W < 8)  $error("DATA_W must carry the drive-select bit");

   logic [15:0]       tim [2];
   tcode_t            slv [2];
   logic              hit, ch, is_ctl, start, use_slv, rdy_en;
   logic [1:0]        drv;
   logic [15:0]       tw;
   tcode_t            code;
   logic [CNT_W-1:0]  n_sel, r_sel;

   ide_tim_regs u_regs (
      .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_data, .tim, .slv
   );

   ide_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr    (req_addr),
      .chan_en ({tim[1][B_DEC_EN], tim[0][B_DEC_EN]}),
      .hit     (hit),
      .chan    (ch),
      .is_ctl  (is_ctl)
   );

   assign tw      = tim[ch];
   assign use_slv = tw[B_D1_SEP] && drv[ch];
   assign code    = use_slv ? slv[ch] : tcode_t'({tw[13:12], tw[9:8]});
   assign rdy_en  = drv[ch] ? tw[B_RDY_D1] : tw[B_RDY_D0];
   assign r_sel   = CNT_W'(rec_clks(code.rec));

   if (RSV_SLOW) begin : g_rsv_slow
      assign n_sel = CNT_W'(smp_clks(code.smp, 1'b1));
   end else begin : g_rsv_fast
      assign n_sel = CNT_W'(smp_clks(code.smp, 1'b0));
   end

   assign start = req && hit && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv      <= '0;
         dev_addr <= '0;
         dev_cs   <= '0;
         dev_chan <= 1'b0;
      end else if (start) begin
         dev_addr <= req_addr[2:0];
         dev_cs   <= is_ctl ? 2'b10 : 2'b01;
         dev_chan <= ch;
         if (req_wr && !is_ctl && req_addr[2:0] == 3'd6) drv[ch] <= req_wdata[4];
      end
   end

   ide_strobe_fsm #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_fsm (
      .clk, .rst_n, .start,
      .is_wr    (req_wr),
      .n_clk    (n_sel),
      .r_clk    (r_sel),
      .rdy_en   (rdy_en),
      .rdy      (dev_rdy),
      .wdata    (req_wdata),
      .rdata_in (dev_rdata),
      .strb_rd, .strb_wr, .busy, .done, .rdata,
      .wdata_o  (dev_wdata)
   );

   p_strobe_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_rd || strb_wr) |-> $past(hit && req));
   p_no_start_in_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_rd || strb_wr) |-> !$past(busy));
endmodule

// File: tb/sim_ide_pio_strobe.sv
module sim_ide_pio_strobe;
   logic        clk = 0, rst_n = 0;
   logic        cfg_wr = 0;
   logic [1:0]  cfg_sel = 0;
   logic [15:0] cfg_data = 0;
   logic        req = 0, req_wr = 0;
   logic [9:0]  req_addr = 0;
   logic [15:0] req_wdata = 0;
   logic        busy, done, strb_rd, strb_wr;
   logic [15:0] rdata, dev_wdata;
   logic        dev_rdy = 1;
   logic [15:0] dev_rdata = 16'hA5C3;
   logic [2:0]  dev_addr;
   logic [1:0]  dev_cs;
   logic        dev_chan;

   always #10 clk = ~clk;

   ide_pio_strobe u0 (.*);

   int n_chk = 0, n_bad = 0;
   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor on the falling edge
   int hi = 0, lo = 0, np = 0, nr = 0, done_cnt = 0, dbad = 0;
   int width_a [4], gap_a [4];
   int stall_n = 5, stall_k = 0;
   logic sp = 0, rd_seen = 0, wr_seen = 0;
   logic [1:0]  cs_seen = 0;
   logic [2:0]  ad_seen = 0;
   logic [15:0] wd_seen = 0, rd_last = 0;
   always @(negedge clk) begin
      logic s;
      s = strb_rd | strb_wr;
      if (s) begin
         if (!sp) begin gap_a[np] = lo; hi = 1; nr++; end
         else hi++;
         rd_seen |= strb_rd; wr_seen |= strb_wr;
         cs_seen = dev_cs; ad_seen = dev_addr; wd_seen = dev_wdata;
      end else begin
         if (sp) begin
            width_a[np] = hi; if (np < 3) np++;
            lo = 1;
            if (!done) dbad++;
         end else lo++;
         hi = 0;
      end
      if (done) begin
         done_cnt++; rd_last = rdata;
         if (!( !s && sp)) dbad++;
      end
      sp = s;
      dev_rdy = !(hi >= stall_n && hi < stall_n + stall_k);
   end

   task automatic clr;
      np = 0; done_cnt = 0; dbad = 0; rd_seen = 0; wr_seen = 0;
      width_a = '{default: 0}; gap_a = '{default: 0};
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk); #2; cfg_wr = 1; cfg_sel = sel; cfg_data = d;
      @(negedge clk); #2; cfg_wr = 0;
   endtask

   task automatic access(input logic [9:0] a, input logic w, input logic [15:0] d, input int nreq);
      int base = nr;
      int t = 0;
      @(negedge clk); #2; req_addr = a; req_wr = w; req_wdata = d; req = 1;
      while (nr < base + nreq && t < 30) begin @(negedge clk); #2; t++; end
      req = 0;
      t = 0;
      while ((busy || strb_rd || strb_wr) && t < 40) begin @(negedge clk); #2; t++; end
      repeat (2) @(negedge clk);
      #2;
   endtask

   typedef struct packed {
      logic        chan;
      logic [15:0] tim;
      logic [7:0]  slv;
      logic        drv;
      logic [3:0]  sn, k, ew, eg, rq;
   } vec_t;
   // R3 R4 code maps, R5 stall, R6 ignored ready, R7 slave timing, R8 drive select, R10 DMA bits
   localparam vec_t VT [13] = '{
      '{1'b0, 16'h8000, 8'h00, 1'b0, 4'd5, 4'd0, 4'd5, 4'd4, 4'd3},
      '{1'b0, 16'h9100, 8'h00, 1'b0, 4'd4, 4'd0, 4'd4, 4'd3, 4'd4},
      '{1'b1, 16'hA200, 8'h00, 1'b0, 4'd3, 4'd0, 4'd3, 4'd2, 4'd4},
      '{1'b0, 16'hB300, 8'h00, 1'b0, 4'd5, 4'd0, 4'd5, 4'd1, 4'd3},
      '{1'b0, 16'h8002, 8'h00, 1'b0, 4'd5, 4'd3, 4'd8, 4'd4, 4'd5},
      '{1'b0, 16'h8000, 8'h00, 1'b0, 4'd5, 4'd3, 4'd5, 4'd4, 4'd6},
      '{1'b0, 16'hC000, 8'h0B, 1'b1, 4'd3, 4'd0, 4'd3, 4'd1, 4'd7},
      '{1'b0, 16'h8000, 8'h0B, 1'b1, 4'd5, 4'd0, 4'd5, 4'd4, 4'd7},
      '{1'b1, 16'h8015, 8'h00, 1'b0, 4'd5, 4'd0, 4'd5, 4'd4, 4'd10},
      '{1'b1, 16'hC000, 8'hB0, 1'b1, 4'd3, 4'd0, 4'd3, 4'd1, 4'd7},
      '{1'b0, 16'h8020, 8'h00, 1'b1, 4'd5, 4'd2, 4'd7, 4'd4, 4'd8},
      '{1'b0, 16'h8020, 8'h00, 1'b0, 4'd5, 4'd2, 4'd5, 4'd4, 4'd8},
      '{1'b0, 16'hD100, 8'h0B, 1'b0, 4'd4, 4'd0, 4'd4, 4'd3, 4'd8}
   };

   logic finished = 0;
   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      // R1 reset state
      check("R1 strobe after reset", int'(strb_rd | strb_wr), 0);
      check("R1 done after reset", int'(done), 0);
      check("R1 busy after reset", int'(busy), 0);
      rst_n = 1;
      clr(); access(10'h1F0, 1'b0, 0, 1);
      check("R1 no strobe with reset timing", np, 0);

      // R2 decode
      cfg(2'd0, 16'h8000);
      clr(); access(10'h170, 1'b0, 0, 1);
      check("R2 disabled channel ignored", np, 0);
      clr(); access(10'h1F8, 1'b0, 0, 1);
      check("R2 unmatched address ignored", np + done_cnt, 0);
      clr(); access(10'h376, 1'b0, 0, 1);
      check("R2 disabled control ignored", np, 0);
      clr(); access(10'h3F6, 1'b0, 0, 1);
      check("R2 control address strobes", np, 1);
      check("R2 control select", int'(cs_seen), 2);

      // R9 write then read
      clr(); access(10'h1F2, 1'b1, 16'h1234, 1);
      check("R9 write strobe", int'(wr_seen), 1);
      check("R9 no read strobe on write", int'(rd_seen), 0);
      check("R9 write data", int'(wd_seen), 16'h1234);
      check("R2 command select", int'(cs_seen), 1);
      check("R2 offset", int'(ad_seen), 2);
      clr(); access(10'h1F0, 1'b0, 0, 1);
      check("R9 read strobe", int'(rd_seen), 1);
      check("R9 no write strobe on read", int'(wr_seen), 0);
      check("R9 one done", done_cnt, 1);
      check("R9 done in first low clock", dbad, 0);
      check("R9 read data", int'(rd_last), 16'hA5C3);

      // table walk
      foreach (VT[i]) begin
         vec_t v;
         logic [9:0] base;
         v = VT[i];
         base = v.chan ? 10'h170 : 10'h1F0;
         cfg({1'b0, v.chan}, v.tim);
         cfg(2'd2, {8'h00, v.slv});
         stall_k = 0;
         access(base + 10'd6, 1'b1, {11'd0, v.drv, 4'd0}, 1);
         stall_n = int'(v.sn); stall_k = int'(v.k);
         clr(); access(base, 1'b0, 0, 2);
         check($sformatf("R%0d vector %0d width", v.rq, i), width_a[0], int'(v.ew));
         check($sformatf("R%0d vector %0d gap", v.rq, i), gap_a[1], int'(v.eg));
         stall_k = 0;
      end

      finished = 1;
      summary();
   end
endmodule